// File: doc/BRIEF.md
# Lane-wise saturating add, subtract and accumulate unit

This block is a registered SIMD datapath. It splits a 128-bit operand pair into lanes of 8, 16, 32 or 64 bits. In each lane it performs a saturating add, a saturating subtract or a mixed-signedness saturating accumulate. Every lane is computed independently: no carry crosses a lane boundary. A scalar flag restricts the work to lane 0. A width flag selects a 64-bit register, in which case only the lower half of the vector is computed.

The two accumulate operations are different from the other four. They add the first source to the current destination value, and they read the two lanes with opposite signedness. When any active lane clamps, a sticky saturation bit is set in a 32-bit status word. A separate clear input clears that bit.

Results appear one clock after the request. A two-state output stage tracks whether the result register holds a fresh result:
- `OS_IDLE`: no fresh result.
- `OS_VALID`: the result register holds a fresh result.

The stage has two transitions:
- LOAD: taken from either state when `in_valid` is high. The next state is `OS_VALID`.
- DRAIN: taken from either state when `in_valid` is low. The next state is `OS_IDLE`.

Top module: `sat_lane_unit`

## Requirements
- R1: `size` values 0, 1, 2 and 3 select lanes of 8, 16, 32 and 64 bits. The active lane count is (register bytes) >> `size`. Each lane is computed independently, with no carry or borrow between lanes.
- R2: When `scalar`=1, only lane 0 is computed. Every other result bit is zero, and a saturating value in any other lane has no effect on the result or on the status bit.
- R3: When `wide`=0 (64-bit register), or whenever `scalar`=1, result bits 127:64 are zero. The upper-half inputs then have no effect on the result or on the status bit.
- R4: `op`=0 is a signed add and `op`=2 is a signed subtract (first source minus second source). Both clamp to the signed range of the lane.
- R5: `op`=1 is an unsigned add and `op`=3 is an unsigned subtract. Both clamp to the range from 0 to the all-ones lane value, so a borrow gives 0.
- R6: `op`=4 adds `src_a`, read as unsigned, to `acc_in`, read as signed. The sum clamps to the signed range of the lane.
- R7: `op`=5 adds `src_a`, read as signed, to `acc_in`, read as unsigned. The sum clamps to the unsigned range of the lane.
- R8: If an accepted operation clamps any active lane, bit 27 of `stat_q` becomes 1 on the next clock. The bit stays 1 through later operations that do not clamp. All other `stat_q` bits are always 0.
- R9: A `stat_clr` pulse clears bit 27 on the next clock. If a clamping operation is accepted in the same cycle, the bit is set instead (set wins).
- R10: `out_valid` and `result` update one clock after `in_valid`. Without `in_valid`, `out_valid` is 0 on the next clock and `result` holds its value. After reset, `out_valid`, `result` and `stat_q` are 0.
- R11: `op` values 6 and 7 are reserved. They produce an all-zero result and never set the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept an operation this cycle |
| op | input | 3 | Operation code (0..5, 6 and 7 reserved) |
| size | input | 2 | Lane size code |
| scalar | input | 1 | Compute lane 0 only |
| wide | input | 1 | 1 = 128-bit register, 0 = 64-bit register |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| acc_in | input | 128 | Current destination vector, used as accumulator |
| stat_clr | input | 1 | Clear the sticky saturation bit |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 128 | Registered result vector |
| stat_q | output | 32 | Status word, bit 27 is sticky saturation |

## Verification
Directed cases place extreme values in every lane: values just past the signed maximum and minimum, 0 minus 1, and all-ones plus a small value. These cases separate correct clamping from wrap-around for each lane size. A pattern that does not saturate but would carry between lanes shows that the lanes are isolated. Cases that put saturating data only in inactive lanes (scalar mode or 64-bit register) show that such data reaches neither the result nor the status bit. Accumulate cases pick values whose reading under the wrong signedness would give a different clamp. A long random stream, with gaps in `in_valid` and random clear pulses, is compared every clock against a behavioural model.

// File: rtl/satlane_pkg.sv
package satlane_pkg;
    typedef enum logic [2:0] {
        OP_SADD = 3'd0,
        OP_UADD = 3'd1,
        OP_SSUB = 3'd2,
        OP_USUB = 3'd3,
        OP_SACC = 3'd4,
        OP_UACC = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } sat_op_e;

    typedef enum logic {
        OS_IDLE  = 1'b0,
        OS_VALID = 1'b1
    } out_state_e;
endpackage

// File: rtl/satlane_elem.sv
module satlane_elem
    import satlane_pkg::*;
#(
    parameter int W = 8
) (
    input  sat_op_e        op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [W-1:0]   d_i,
    output logic [W-1:0]   r_o,
    output logic           sat_o
);
    localparam int XW = W + 2;

    logic signed [XW-1:0] x, y, s;
    logic                 signed_out;
    logic                 live;
    logic                 fits;

    function automatic logic signed [XW-1:0] sext(input logic [W-1:0] v);
        return XW'(signed'(v));
    endfunction

    function automatic logic signed [XW-1:0] zext(input logic [W-1:0] v);
        return $signed({2'b00, v});
    endfunction

    always_comb begin
        x          = '0;
        y          = '0;
        s          = '0;
        signed_out = 1'b0;
        live       = 1'b1;
        unique case (op_i)
            OP_SADD: begin x = sext(a_i); y = sext(b_i); s = x + y; signed_out = 1'b1; end
            OP_UADD: begin x = zext(a_i); y = zext(b_i); s = x + y; end
            OP_SSUB: begin x = sext(a_i); y = sext(b_i); s = x - y; signed_out = 1'b1; end
            OP_USUB: begin x = zext(a_i); y = zext(b_i); s = x - y; end
            OP_SACC: begin x = zext(a_i); y = sext(d_i); s = x + y; signed_out = 1'b1; end
            OP_UACC: begin x = sext(a_i); y = zext(d_i); s = x + y; end
            default: live = 1'b0;
        endcase
    end

    always_comb begin
        if (signed_out) begin
            fits = (&s[XW-1:W-1]) | ~(|s[XW-1:W-1]);
        end else begin
            fits = ~(|s[XW-1:W]);
        end

        if (!live) begin
            r_o   = '0;
            sat_o = 1'b0;
        end else if (fits) begin
            r_o   = s[W-1:0];
            sat_o = 1'b0;
        end else begin
            sat_o = 1'b1;
            if (signed_out) begin
                r_o = s[XW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
            end else begin
                r_o = s[XW-1] ? '0 : '1;
            end
        end
    end
endmodule

// File: rtl/satlane_size_slice.sv
module satlane_size_slice
    import satlane_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int W      = 8
) (
    input  sat_op_e             op_i,
    input  logic                scalar_i,
    input  logic                wide_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    input  logic [DATA_W-1:0]   d_i,
    output logic [DATA_W-1:0]   res_o,
    output logic                sat_o
);
    localparam int N    = DATA_W / W;
    localparam int HALF = N / 2;

    logic [N-1:0] lane_sat;
    logic [N-1:0] lane_act;

    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam bit IS_FIRST = (i == 0);
        localparam bit IN_LOW   = (i < HALF);
        logic [W-1:0] lr;
        logic         ls;

        satlane_elem #(.W(W)) u_elem (
            .op_i  (op_i),
            .a_i   (a_i[i*W +: W]),
            .b_i   (b_i[i*W +: W]),
            .d_i   (d_i[i*W +: W]),
            .r_o   (lr),
            .sat_o (ls)
        );

        assign lane_act[i]      = IS_FIRST | (~scalar_i & (wide_i | IN_LOW));
        assign lane_sat[i]      = ls & lane_act[i];
        assign res_o[i*W +: W]  = lane_act[i] ? lr : '0;
    end

    assign sat_o = |lane_sat;
endmodule

// File: rtl/sat_lane_unit.sv
module sat_lane_unit
    import satlane_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int STAT_W = 32,
    parameter int QC_BIT = 27
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          op,
    input  logic [1:0]          size,
    input  logic                scalar,
    input  logic                wide,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    input  logic [DATA_W-1:0]   acc_in,
    input  logic                stat_clr,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic [STAT_W-1:0]   stat_q
);
    localparam int NUM_SIZES = 4;
    localparam int HALF_W    = DATA_W / 2;

    sat_op_e           op_e;
    logic [DATA_W-1:0] res_by_size [NUM_SIZES];
    logic [NUM_SIZES-1:0] sat_by_size;
    logic [DATA_W-1:0] res_next;
    logic              sat_any;
    out_state_e        ost, ost_next;
    logic              qc_flag;
    logic [DATA_W-1:0] result_q;

    assign op_e = sat_op_e'(op);

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        satlane_size_slice #(.DATA_W(DATA_W), .W(8 << g)) u_slice (
            .op_i     (op_e),
            .scalar_i (scalar),
            .wide_i   (wide),
            .a_i      (src_a),
            .b_i      (src_b),
            .d_i      (acc_in),
            .res_o    (res_by_size[g]),
            .sat_o    (sat_by_size[g])
        );
    end

    always_comb begin
        res_next = res_by_size[size];
        sat_any  = sat_by_size[size];
    end

    // Output stage state: LOAD on in_valid, DRAIN otherwise
    always_comb begin
        unique case (ost)
            OS_IDLE:  ost_next = in_valid ? OS_VALID : OS_IDLE;
            OS_VALID: ost_next = in_valid ? OS_VALID : OS_IDLE;
            default:  ost_next = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ost <= OS_IDLE;
        end else begin
            ost <= ost_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            qc_flag  <= 1'b0;
        end else begin
            if (in_valid) begin
                result_q <= res_next;
            end
            if (in_valid && sat_any) begin
                qc_flag <= 1'b1;
            end else if (stat_clr) begin
                qc_flag <= 1'b0;
            end
        end
    end

    assign out_valid = (ost == OS_VALID);
    assign result    = result_q;
    assign stat_q    = STAT_W'(qc_flag) << QC_BIT;

    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_any) |=> stat_q[QC_BIT]);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[QC_BIT] && !stat_clr) |=> stat_q[QC_BIT]);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !(in_valid && sat_any)) |=> !stat_q[QC_BIT]);
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (scalar || !wide)) |=> (result[DATA_W-1:HALF_W] == '0));
    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2] && op[1]) |=> (result == '0));
endmodule

// File: tb/sat_lane_unit_bench.sv
`timescale 1ns/1ps
module sat_lane_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   op = '0;
    logic [1:0]   size = '0;
    logic         scalar = 1'b0;
    logic         wide = 1'b1;
    logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
    logic         stat_clr = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic [31:0]  stat_q;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    bit started = 0;

    localparam logic [31:0] QC = 32'h0800_0000;

    always #2 clk = ~clk;

    sat_lane_unit u_sat_lane_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
        .scalar(scalar), .wide(wide), .src_a(src_a), .src_b(src_b),
        .acc_in(acc_in), .stat_clr(stat_clr), .out_valid(out_valid),
        .result(result), .stat_q(stat_q)
    );

    function automatic logic signed [67:0] lane_val(input logic [63:0] e, input int w, input bit sg);
        logic signed [67:0] v;
        v = $signed({4'b0, e});
        if (sg && e[w-1]) v = v - (68'sd1 <<< w);
        return v;
    endfunction

    function automatic logic [128:0] model(input logic [2:0] o, input logic [1:0] sz,
                                           input logic sc, input logic wd,
                                           input logic [127:0] va, input logic [127:0] vb,
                                           input logic [127:0] vd);
        int w, n;
        logic [127:0] res;
        logic sat;
        logic [63:0] m;
        bit sa, sb, so;
        w = 8 << sz;
        n = (wd ? 16 : 8) >> sz;
        if (sc) n = 1;
        res = '0;
        sat = 1'b0;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        if (o > 3'd5) return '0;
        case (o)
            3'd0, 3'd2: begin sa = 1; sb = 1; so = 1; end
            3'd1, 3'd3: begin sa = 0; sb = 0; so = 0; end
            3'd4:       begin sa = 0; sb = 1; so = 1; end
            default:    begin sa = 1; sb = 0; so = 0; end
        endcase
        for (int i = 0; i < n; i++) begin
            logic [63:0] ea, eb;
            logic signed [67:0] x, y, s, lo, hi;
            ea = 64'(va >> (i*w)) & m;
            eb = 64'(((o > 3'd3) ? vd : vb) >> (i*w)) & m;
            x = lane_val(ea, w, sa);
            y = lane_val(eb, w, sb);
            s = (o == 3'd2 || o == 3'd3) ? x - y : x + y;
            lo = so ? -(68'sd1 <<< (w-1)) : 68'sd0;
            hi = so ? (68'sd1 <<< (w-1)) - 68'sd1 : (68'sd1 <<< w) - 68'sd1;
            if (s > hi) begin s = hi; sat = 1'b1; end
            if (s < lo) begin s = lo; sat = 1'b1; end
            res = res | (128'(64'(s) & m) << (i*w));
        end
        return {sat, res};
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0, 3'd2: return "R4";
            3'd1, 3'd3: return "R5";
            3'd4:       return "R6";
            3'd5:       return "R7";
            default:    return "R11";
        endcase
    endfunction

    // behavioural reference, advanced every clock
    logic         exp_valid = 1'b0;
    logic [127:0] exp_res = '0;
    logic         exp_qc = 1'b0;
    string        exp_tag = "R10";

    always @(posedge clk) begin
        logic [128:0] mr;
        mr = model(op, size, scalar, wide, src_a, src_b, acc_in);
        if (!rst_n) begin
            exp_valid <= 1'b0; exp_res <= '0; exp_qc <= 1'b0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid) begin
                exp_res <= mr[127:0];
                exp_tag <= tag_of(op);
            end
            if (in_valid && mr[128]) exp_qc <= 1'b1;
            else if (stat_clr)       exp_qc <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && started && !done) begin
            checks++;
            if (out_valid !== exp_valid || result !== exp_res || stat_q !== (exp_qc ? QC : 32'h0)) begin
                errors++;
                $display("FAIL %s/R8/R10 per-cycle: valid=%0b res=%h stat=%h expected valid=%0b res=%h stat=%h",
                         exp_tag, out_valid, result, stat_q, exp_valid, exp_res, exp_qc ? QC : 32'h0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 50000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic go(input logic [2:0] o, input logic [1:0] sz, input logic sc, input logic wd,
                      input logic [127:0] va, input logic [127:0] vb, input logic [127:0] vd,
                      input logic clr);
        @(negedge clk);
        op = o; size = sz; scalar = sc; wide = wd;
        src_a = va; src_b = vb; acc_in = vd;
        in_valid = 1'b1; stat_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; stat_clr = 1'b0;
    endtask

    task automatic clear_stat();
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset valid", 128'(out_valid), 128'd0);
        check("R10 reset result", result, 128'd0);
        check("R10 reset stat", 128'(stat_q), 128'd0);
        rst_n = 1'b1;
        started = 1;

        // R1 no carry between 8-bit lanes
        go(3'd1, 2'd0, 0, 1, {16{8'h01}}, {16{8'h02}}, '0, 0);
        check("R1 uadd8 lanes", result, {16{8'h03}});
        check("R1 no sat stat", 128'(stat_q), 128'd0);
        go(3'd1, 2'd1, 0, 1, {8{16'h00FF}}, {8{16'h0001}}, '0, 0);
        check("R1 uadd16 carry inside lane", result, {8{16'h0100}});

        // R4 signed add / subtract clamps
        go(3'd0, 2'd0, 0, 1, {16{8'h7F}}, {16{8'h01}}, '0, 0);
        check("R4 sadd8 clamp max", result, {16{8'h7F}});
        check("R8 sat sets stat", 128'(stat_q), 128'(QC));
        go(3'd2, 2'd1, 0, 1, {8{16'h8000}}, {8{16'h0001}}, '0, 0);
        check("R4 ssub16 clamp min", result, {8{16'h8000}});
        go(3'd0, 2'd3, 0, 1, {2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'h1}}, '0, 0);
        check("R4 sadd64 clamp max", result, {2{64'h7FFF_FFFF_FFFF_FFFF}});

        // R8 sticky over a non-saturating op
        go(3'd1, 2'd0, 0, 1, '0, '0, '0, 0);
        check("R8 sticky", 128'(stat_q), 128'(QC));
        clear_stat();
        check("R9 clear", 128'(stat_q), 128'd0);

        // R5 unsigned clamps
        go(3'd3, 2'd3, 0, 1, '0, {2{64'h1}}, '0, 0);
        check("R5 usub64 borrow to zero", result, 128'd0);
        go(3'd1, 2'd2, 0, 1, {4{32'hFFFF_FFF0}}, {4{32'h20}}, '0, 0);
        check("R5 uadd32 clamp ones", result, {4{32'hFFFF_FFFF}});
        clear_stat();

        // R6 signed accumulate of unsigned source
        go(3'd4, 2'd0, 0, 1, {16{8'hFF}}, '0, {16{8'h80}}, 0);
        check("R6 sacc 255+-128", result, {16{8'h7F}});
        check("R6 no sat", 128'(stat_q), 128'd0);
        go(3'd4, 2'd0, 0, 1, {16{8'hFF}}, '0, {16{8'h01}}, 0);
        check("R6 sacc clamp", result, {16{8'h7F}});
        check("R6 sat stat", 128'(stat_q), 128'(QC));
        clear_stat();

        // R7 unsigned accumulate of signed source
        go(3'd5, 2'd0, 0, 1, {16{8'h80}}, '0, {16{8'hFF}}, 0);
        check("R7 uacc -128+255", result, {16{8'h7F}});
        check("R7 no sat", 128'(stat_q), 128'd0);
        go(3'd5, 2'd0, 0, 1, {16{8'hFF}}, '0, '0, 0);
        check("R7 uacc clamp zero", result, 128'd0);
        check("R7 sat stat", 128'(stat_q), 128'(QC));
        clear_stat();

        // R2 scalar: only lane 0, other lanes saturating but ignored
        go(3'd1, 2'd1, 1, 1, {{7{16'hFFFF}}, 16'h0001}, {8{16'h0001}}, '0, 0);
        check("R2 scalar lane0 only", result, 128'h2);
        check("R2 scalar no stat", 128'(stat_q), 128'd0);

        // R3 64-bit register: upper lanes ignored
        go(3'd0, 2'd2, 0, 0, {64'h7FFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001},
           {{2{32'h1}}, {2{32'h2}}}, '0, 0);
        check("R3 low half only", result, {64'h0, 64'h0000_0003_0000_0003});
        check("R3 no stat", 128'(stat_q), 128'd0);

        // R11 reserved op
        go(3'd6, 2'd0, 0, 1, {16{8'h7F}}, {16{8'h7F}}, '0, 0);
        check("R11 reserved zero", result, 128'd0);
        check("R11 no stat", 128'(stat_q), 128'd0);

        // R9 set wins over clear
        go(3'd0, 2'd0, 0, 1, {16{8'h7F}}, {16{8'h7F}}, '0, 1);
        check("R9 set wins", 128'(stat_q), 128'(QC));

        // R10 hold without in_valid
        @(negedge clk);
        check("R10 drain valid", 128'(out_valid), 128'd0);
        check("R10 hold result", result, {16{8'h7F}});

        // random stream compared by the per-cycle model
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            in_valid = ($urandom_range(3) != 0);
            stat_clr = ($urandom_range(7) == 0);
            op       = 3'($urandom_range(7));
            size     = 2'($urandom_range(3));
            scalar   = ($urandom_range(3) == 0);
            wide     = ($urandom_range(1) == 1);
            src_a    = {$urandom, $urandom, $urandom, $urandom};
            src_b    = {$urandom, $urandom, $urandom, $urandom};
            acc_in   = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(3) == 0) src_a = {16{8'h7F}};
            if ($urandom_range(3) == 0) src_b = '0;
        end
        @(negedge clk);
        in_valid = 1'b0; stat_clr = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule